// File: doc/BRIEF.md
# Serial Audio Link Input Frame Packer

This block is the codec-side transmitter for the input direction of a serial audio link. Each frame is 256 bit clocks long: a 16-bit tag slot followed by twelve 20-bit data slots. The block serializes the frame on a single data line, one bit per rising edge of the bit clock, so that the controller can sample each bit on the falling edge. A rising edge of the frame sync input starts a frame. The tag slot reports codec readiness and marks which data slots hold valid content.

Record samples come from the ADC at a resolution fixed by a parameter: 16, 18 or 20 bits. A one-cycle strobe captures a left/right pair. The pair is sent in the next frame that starts, placed at the top of its 20-bit slot with zeros below it. The GPIO input levels go into the last slot. Every slot the codec does not support, and every reserved slot, is driven as zeros. The status slots are also zero here, because the register file is not part of this block.

Top module: `afp_input_framer`

## Requirements
- R1: While reset is asserted, and whenever no frame is in progress, `sdata_in` is 0. A frame ends after exactly 256 bits.
- R2: If `sync` is sampled high at clock edge N after being low at edge N-1, then edge N+1 launches the first frame bit (tag bit 15). Each later edge launches the next bit.
- R3: The tag slot is sent MSB first. Bit 15 equals `codec_ready` as sampled at the start edge. Bits 12 and 11 (the left and right slot valid flags) equal the new-sample flag. Bit 3 (the GPIO slot valid flag) equals the parameter `GPIO_TAG_EN`. All other tag bits are 0.
- R4: Slot 3 carries the left sample and slot 4 carries the right sample, each MSB first, starting at slot bit 19.
- R5: When `ADC_RES` is below 20, the 20-`ADC_RES` trailing bits of slots 3 and 4 are 0.
- R6: Slots 1, 2 and 5 through 11 are all zeros.
- R7: Slot 12 carries `gpio_in`, as sampled at the start edge, MSB first from slot bit 19. Any bits below `GPIO_W` are 0.
- R8: A `rec_valid` strobe captures `rec_left` and `rec_right` and sets a new-sample flag. The next frame start consumes and clears the flag. A frame started without the flag sends slots 3 and 4 as zeros.
- R9: A `rec_valid` strobe on the same edge as a frame start does not count toward that frame. The frame it starts uses the flag and samples held before that edge. The new pair is sent in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data launched on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync from controller; rising edge starts a frame |
| codec_ready | input | 1 | Codec ready indication for tag bit 15 |
| rec_valid | input | 1 | One-cycle strobe: new record sample pair present |
| rec_left | input | ADC_RES | Left record sample |
| rec_right | input | ADC_RES | Right record sample |
| gpio_in | input | GPIO_W | GPIO input levels |
| sdata_in | output | 1 | Serial input-frame data to controller |

## Verification
The bench compares every serial bit against a frame it builds from the requirements. This means a one-cycle shift of the frame start, or a slot bit sent LSB first, shows up as a run of mismatches. Samples made of all ones check that the pad bits below an 18-bit sample stay 0, rather than being filled from a right-justified sample. A frame with no prior strobe must show cleared valid flags and empty record slots; a design that keeps the flag set would resend stale data. A strobe placed on the exact start edge must be held back for the following frame; a design that gives the strobe priority backwards would mark the current frame valid.

// File: rtl/afp_pkg.sv
package afp_pkg;
   localparam int TAG_W       = 16;
   localparam int SLOT_W      = 20;
   localparam int NUM_SLOTS   = 12;
   localparam int FRAME_BITS  = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int SLOT_LEFT   = 3;
   localparam int SLOT_RIGHT  = 4;
   localparam int SLOT_GPIO   = 12;
   localparam int TAG_READY   = TAG_W - 1;
   localparam int TAG_LEFT    = TAG_W - 1 - SLOT_LEFT;
   localparam int TAG_RIGHT   = TAG_W - 1 - SLOT_RIGHT;
   localparam int TAG_GPIO    = TAG_W - 1 - SLOT_GPIO;
   localparam int BIT_IDX_W   = $clog2(SLOT_W);
   localparam int TAG_IDX_W   = $clog2(TAG_W);
   localparam int SLOT_IDX_W  = $clog2(NUM_SLOTS + 1);

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [SLOT_W-1:0] left;
      logic [SLOT_W-1:0] right;
      logic [SLOT_W-1:0] gpio;
   } frame_t;
endpackage

// File: rtl/afp_frame_counter.sv
module afp_frame_counter
   import afp_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output logic                  active,
   output logic [SLOT_IDX_W-1:0] slot_idx,
   output logic [BIT_IDX_W-1:0]  bit_idx
);
   localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(NUM_SLOTS);
   localparam logic [BIT_IDX_W-1:0]  TAG_TOP   = BIT_IDX_W'(TAG_W - 1);
   localparam logic [BIT_IDX_W-1:0]  SLOT_TOP  = BIT_IDX_W'(SLOT_W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         slot_idx <= '0;
         bit_idx  <= '0;
      end else if (start) begin
         active   <= 1'b1;
         slot_idx <= '0;
         bit_idx  <= TAG_TOP;
      end else if (active) begin
         if (bit_idx == '0) begin
            if (slot_idx == LAST_SLOT) begin
               active <= 1'b0;
            end else begin
               slot_idx <= slot_idx + 1'b1;
               bit_idx  <= SLOT_TOP;
            end
         end else begin
            bit_idx <= bit_idx - 1'b1;
         end
      end
   end
endmodule

// File: rtl/afp_sample_hold.sv
module afp_sample_hold
   import afp_pkg::*;
#(
   parameter int RES = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              consume,
   input  logic [RES-1:0]    in_left,
   input  logic [RES-1:0]    in_right,
   output logic [SLOT_W-1:0] slot_left,
   output logic [SLOT_W-1:0] slot_right,
   output logic              fresh
);
   localparam int PAD_W = SLOT_W - RES;

   logic [RES-1:0] hold_l, hold_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         fresh  <= 1'b0;
      end else if (capture) begin
         hold_l <= in_left;
         hold_r <= in_right;
         fresh  <= 1'b1;
      end else if (consume) begin
         fresh  <= 1'b0;
      end
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign slot_left  = hold_l;
         assign slot_right = hold_r;
      end else begin : g_pad
         assign slot_left  = {hold_l, {PAD_W{1'b0}}};
         assign slot_right = {hold_r, {PAD_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/afp_bit_select.sv
module afp_bit_select
   import afp_pkg::*;
(
   input  frame_t                frame,
   input  logic [SLOT_IDX_W-1:0] slot_idx,
   input  logic [BIT_IDX_W-1:0]  bit_idx,
   output logic                  bit_val
);
   localparam logic [SLOT_IDX_W-1:0] S_TAG   = '0;
   localparam logic [SLOT_IDX_W-1:0] S_LEFT  = SLOT_IDX_W'(SLOT_LEFT);
   localparam logic [SLOT_IDX_W-1:0] S_RIGHT = SLOT_IDX_W'(SLOT_RIGHT);
   localparam logic [SLOT_IDX_W-1:0] S_GPIO  = SLOT_IDX_W'(SLOT_GPIO);

   always_comb begin
      bit_val = 1'b0;
      case (slot_idx)
         S_TAG: begin
            if (bit_idx < BIT_IDX_W'(TAG_W))
               bit_val = frame.tag[bit_idx[TAG_IDX_W-1:0]];
         end
         S_LEFT:  bit_val = frame.left[bit_idx];
         S_RIGHT: bit_val = frame.right[bit_idx];
         S_GPIO:  bit_val = frame.gpio[bit_idx];
         default: bit_val = 1'b0;
      endcase
   end
endmodule

// File: rtl/afp_input_framer.sv
module afp_input_framer
   import afp_pkg::*;
#(
   parameter int ADC_RES     = 18,
   parameter int GPIO_W      = 20,
   parameter bit GPIO_TAG_EN = 1'b1
) (
   input  logic               bit_clk,
   input  logic               rst_n,
   input  logic               sync,
   input  logic               codec_ready,
   input  logic               rec_valid,
   input  logic [ADC_RES-1:0] rec_left,
   input  logic [ADC_RES-1:0] rec_right,
   input  logic [GPIO_W-1:0]  gpio_in,
   output logic               sdata_in
);
   localparam int GPIO_PAD = SLOT_W - GPIO_W;

   generate
      if (ADC_RES != 16 && ADC_RES != 18 && ADC_RES != 20) begin : g_bad_res
         $error("afp_input_framer: ADC_RES must be 16, 18 or 20");
      end
      if (GPIO_W < 1 || GPIO_W > SLOT_W) begin : g_bad_gpio
         $error("afp_input_framer: GPIO_W must be 1 to SLOT_W");
      end
   endgenerate

   logic                  sync_q;
   logic                  start;
   logic [SLOT_W-1:0]     held_left, held_right, gpio_slot;
   logic                  held_new;
   logic                  gpio_tag;
   frame_t                frame_nxt, frame_q;
   logic                  frm_active;
   logic [SLOT_IDX_W-1:0] slot_idx;
   logic [BIT_IDX_W-1:0]  bit_idx;
   logic                  sel_bit;
   logic                  sdata_q;

   always_ff @(posedge bit_clk) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync;
   end
   assign start = sync & ~sync_q;

   afp_sample_hold #(.RES(ADC_RES)) u_hold (
      .clk        (bit_clk),
      .rst_n      (rst_n),
      .capture    (rec_valid),
      .consume    (start),
      .in_left    (rec_left),
      .in_right   (rec_right),
      .slot_left  (held_left),
      .slot_right (held_right),
      .fresh      (held_new)
   );

   generate
      if (GPIO_PAD == 0) begin : g_gpio_full
         assign gpio_slot = gpio_in;
      end else begin : g_gpio_pad
         assign gpio_slot = {gpio_in, {GPIO_PAD{1'b0}}};
      end
      if (GPIO_TAG_EN) begin : g_gpio_tag_on
         assign gpio_tag = 1'b1;
      end else begin : g_gpio_tag_off
         assign gpio_tag = 1'b0;
      end
   endgenerate

   always_comb begin
      frame_nxt                = '0;
      frame_nxt.tag[TAG_READY] = codec_ready;
      frame_nxt.tag[TAG_LEFT]  = held_new;
      frame_nxt.tag[TAG_RIGHT] = held_new;
      frame_nxt.tag[TAG_GPIO]  = gpio_tag;
      frame_nxt.left           = held_new ? held_left  : '0;
      frame_nxt.right          = held_new ? held_right : '0;
      frame_nxt.gpio           = gpio_slot;
   end

   always_ff @(posedge bit_clk) begin
      if (!rst_n)     frame_q <= '0;
      else if (start) frame_q <= frame_nxt;
   end

   afp_frame_counter u_cnt (
      .clk      (bit_clk),
      .rst_n    (rst_n),
      .start    (start),
      .active   (frm_active),
      .slot_idx (slot_idx),
      .bit_idx  (bit_idx)
   );

   afp_bit_select u_sel (
      .frame    (frame_q),
      .slot_idx (slot_idx),
      .bit_idx  (bit_idx),
      .bit_val  (sel_bit)
   );

   always_ff @(posedge bit_clk) begin
      if (!rst_n) sdata_q <= 1'b0;
      else        sdata_q <= frm_active & sel_bit;
   end
   assign sdata_in = sdata_q;
endmodule

// File: rtl/afp_input_framer_chk.sv
module afp_input_framer_chk
   import afp_pkg::*;
#(
   parameter int ADC_RES = 18
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sync,
   input logic                  sync_q,
   input logic                  active,
   input logic [SLOT_IDX_W-1:0] slot_idx,
   input logic [BIT_IDX_W-1:0]  bit_idx,
   input logic                  sdata
);
   logic is_start;
   assign is_start = sync & ~sync_q;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !sdata) else $error("idle output not low"); // R1

   AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot_idx == SLOT_IDX_W'(NUM_SLOTS) && bit_idx == '0 && !is_start)
      |=> !active) else $error("frame did not end"); // R1

   AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      is_start |=> (active && slot_idx == '0 && bit_idx == BIT_IDX_W'(TAG_W - 1)))
      else $error("frame start misaligned"); // R2

   AST_TAG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot_idx == '0 && bit_idx != BIT_IDX_W'(TAG_READY)
       && bit_idx != BIT_IDX_W'(TAG_LEFT) && bit_idx != BIT_IDX_W'(TAG_RIGHT)
       && bit_idx != BIT_IDX_W'(TAG_GPIO)) |=> !sdata)
      else $error("spare tag bit set"); // R3

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (slot_idx == SLOT_IDX_W'(SLOT_LEFT) || slot_idx == SLOT_IDX_W'(SLOT_RIGHT))
       && bit_idx < BIT_IDX_W'(SLOT_W - ADC_RES)) |=> !sdata)
      else $error("sample pad bit set"); // R5

   AST_UNUSED_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot_idx != '0 && slot_idx != SLOT_IDX_W'(SLOT_LEFT)
       && slot_idx != SLOT_IDX_W'(SLOT_RIGHT) && slot_idx != SLOT_IDX_W'(SLOT_GPIO))
      |=> !sdata) else $error("unsupported slot not zero"); // R6
endmodule

bind afp_input_framer afp_input_framer_chk #(.ADC_RES(ADC_RES)) u_chk (
   .clk      (bit_clk),
   .rst_n    (rst_n),
   .sync     (sync),
   .sync_q   (sync_q),
   .active   (frm_active),
   .slot_idx (slot_idx),
   .bit_idx  (bit_idx),
   .sdata    (sdata_in)
);

// File: tb/afp_input_framer_tb.sv
`timescale 1ns/1ps
module afp_input_framer_tb;
   localparam int RES = 18;
   localparam int GW  = 20;

   logic          clk = 1'b0;
   logic          rst_n, sync, codec_ready, rec_valid;
   logic [RES-1:0] rec_left, rec_right;
   logic [GW-1:0]  gpio_in;
   logic          sdata_in;

   always #5 clk = ~clk;

   afp_input_framer #(.ADC_RES(RES), .GPIO_W(GW), .GPIO_TAG_EN(1'b1)) u_dut (
      .bit_clk(clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
      .rec_valid(rec_valid), .rec_left(rec_left), .rec_right(rec_right),
      .gpio_in(gpio_in), .sdata_in(sdata_in)
   );

   int    checks = 0;
   int    fails = 0;
   int    frames_done = 0;
   logic  exp_q[$];
   string req_q[$];

   task automatic check(input logic got, input logic exp, input string req, input int pos);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s bit %0d actual=%0b expected=%0b", req, pos, got, exp);
      end
   endtask

   // Scoreboard driver side: expected frame built from the requirements
   task automatic push_frame(input logic ready, input logic vld,
                             input logic [RES-1:0] l, input logic [RES-1:0] r,
                             input logic [GW-1:0] g);
      for (int p = 15; p >= 0; p--) begin
         logic b;
         b = 1'b0;
         if (p == 15) b = ready;
         else if (p == 12 || p == 11) b = vld;
         else if (p == 3) b = 1'b1;
         exp_q.push_back(b);
         req_q.push_back(p == 15 ? "R2" : "R3");
      end
      for (int s = 1; s <= 12; s++) begin
         for (int b = 19; b >= 0; b--) begin
            if (s == 3 || s == 4) begin
               if (!vld) begin
                  exp_q.push_back(1'b0); req_q.push_back("R8");
               end else if (b >= 20 - RES) begin
                  exp_q.push_back(s == 3 ? l[b-(20-RES)] : r[b-(20-RES)]);
                  req_q.push_back("R4");
               end else begin
                  exp_q.push_back(1'b0); req_q.push_back("R5");
               end
            end else if (s == 12) begin
               exp_q.push_back(b >= 20 - GW ? g[b-(20-GW)] : 1'b0);
               req_q.push_back("R7");
            end else begin
               exp_q.push_back(1'b0); req_q.push_back("R6");
            end
         end
      end
   endtask

   task automatic pulse_sample(input logic [RES-1:0] l, input logic [RES-1:0] r);
      @(negedge clk);
      rec_valid = 1'b1; rec_left = l; rec_right = r;
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic run_frame(input logic ready, input logic vld,
                            input logic [RES-1:0] el, input logic [RES-1:0] er,
                            input logic [GW-1:0] g, input logic coinc,
                            input logic [RES-1:0] pl, input logic [RES-1:0] pr);
      int target;
      target = frames_done + 1;
      push_frame(ready, vld, el, er, g);
      @(negedge clk);
      codec_ready = ready; gpio_in = g; sync = 1'b1;
      if (coinc) begin
         rec_valid = 1'b1; rec_left = pl; rec_right = pr;
      end
      @(negedge clk);
      rec_valid = 1'b0;
      repeat (15) @(negedge clk);
      sync = 1'b0;
      wait (frames_done == target);
      repeat (3) @(negedge clk);
   endtask

   // Scoreboard monitor side
   initial begin
      forever begin
         @(posedge sync);
         @(posedge clk);
         @(posedge clk);
         for (int j = 0; j < 256; j++) begin
            logic  e;
            string rq;
            @(negedge clk);
            e  = exp_q.pop_front();
            rq = req_q.pop_front();
            check(sdata_in, e, rq, j);
            @(posedge clk);
         end
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(sdata_in, 1'b0, "R1", 256 + k);
            @(posedge clk);
         end
         frames_done++;
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired (R1) actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; sync = 1'b0; codec_ready = 1'b1; rec_valid = 1'b0;
      rec_left = '0; rec_right = '0; gpio_in = '0;
      repeat (4) begin
         @(negedge clk);
         check(sdata_in, 1'b0, "R1", -1); // reset state
      end
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(sdata_in, 1'b0, "R1", -1); // idle before any frame
      end
      // R4 R3: ordinary frame with fresh samples
      pulse_sample(18'h2D5A3, 18'h15C0F);
      run_frame(1'b1, 1'b1, 18'h2D5A3, 18'h15C0F, 20'hA5C3E, 1'b0, '0, '0);
      // R8: no new samples, codec not ready
      run_frame(1'b0, 1'b0, '0, '0, 20'h0F0F0, 1'b0, '0, '0);
      // R5: all-ones samples expose pad bits
      pulse_sample('1, '1);
      run_frame(1'b1, 1'b1, '1, '1, 20'hFFFFF, 1'b0, '0, '0);
      // R9: strobe on the start edge goes to the following frame
      run_frame(1'b1, 1'b0, '0, '0, 20'h12345, 1'b1, 18'h1ABCD, 18'h0F00F);
      run_frame(1'b1, 1'b1, 18'h1ABCD, 18'h0F00F, 20'h80001, 1'b0, '0, '0);
      finish_run();
   end
endmodule